// File: doc/BRIEF.md
# External Bus Transfer Sequencer

This block carries out one host command at a time that moves a burst of 32-bit words between a shared-memory word port and a simple local bus. A command names the direction (bus write or bus read), how many words to move, which byte lanes are meaningful, whether the bus address should advance or stay fixed, where in shared memory the data lives (as a byte pointer), and the bus base address. A bus write reads each word from shared memory and then presents it on the bus. A bus read takes each word from the bus and stores it into shared memory. The shared-memory location advances by one word per access in both address modes.

The hold-address mode repeats every access at one bus location, which suits FIFO-style devices. The normal mode walks the bus address upward from the base. When the burst ends, the block gives a one-cycle completion pulse. If the command asked for it, an acknowledge interrupt is pulsed in the same cycle. A misaligned shared-memory pointer is refused: the block flags an error and touches neither port. Unknown opcodes and zero-length commands complete straight away. The local bus uses a single-cycle handshake: a beat finishes in the cycle where the request and ready are both high.

Top module: `ebus_xfer_seq`

## Requirements
- R1: After reset, desc_ready is 1 and lb_req, mem_rd_en, mem_wr_en, done, done_err and sack_irq are all 0.
- R2: Opcode 5'h0C (bus write) moves desc_len words. Word i is read from shared-memory word (desc_mem_ptr/4)+i and then written to the bus.
- R3: Opcode 5'h0D (bus read) moves desc_len words. Word i read from the bus is written to shared-memory word (desc_mem_ptr/4)+i.
- R4: With desc_hold at 0, access i uses bus address desc_bus_base+i, so the last access uses desc_bus_base+desc_len-1.
- R5: With desc_hold at 1, every access of the burst uses bus address desc_bus_base.
- R6: Every bus access drives lb_be equal to the command's desc_be. Bit b enables data bits [8b+7:8b], so bit 0 is the least significant byte lane.
- R7: The shared-memory word address advances by exactly one per access in both address modes.
- R8: A read or write command with desc_len 0 makes no bus or memory access and pulses done. sack_irq pulses with it if desc_irq_en is 1.
- R9: A read or write command whose desc_mem_ptr[1:0] is non-zero makes no bus or memory access. It pulses done with done_err at 1 and sack_irq at 0. This check takes priority over the zero-length rule.
- R10: Any opcode other than 5'h0C or 5'h0D makes no bus or memory access and pulses done. sack_irq pulses with it if desc_irq_en is 1.
- R11: sack_irq is high only in a done cycle of an error-free command whose desc_irq_en was 1. It pulses exactly once for such a command and never for a command with desc_irq_en at 0.
- R12: desc_ready stays 0 from the acceptance cycle until the done pulse, and is 1 again in the cycle after it. An asserted lb_req stays high with lb_addr unchanged until lb_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Command present |
| desc_ready | output | 1 | Block idle, command taken when valid |
| desc_opcode | input | 5 | Command opcode (5'h0C write, 5'h0D read) |
| desc_irq_en | input | 1 | Request acknowledge interrupt on completion |
| desc_len | input | LEN_W | Number of words to move |
| desc_be | input | DATA_W/8 | Byte-lane enables for every access |
| desc_hold | input | 1 | Keep bus address fixed for the burst |
| desc_mem_ptr | input | PTR_W | Shared-memory byte pointer, word aligned |
| desc_bus_base | input | BUS_AW | Bus base address |
| lb_req | output | 1 | Bus access request |
| lb_we | output | 1 | Bus access is a write |
| lb_addr | output | BUS_AW | Bus address |
| lb_be | output | DATA_W/8 | Bus byte-lane enables |
| lb_wdata | output | DATA_W | Bus write data |
| lb_rdata | input | DATA_W | Bus read data, valid with lb_ready |
| lb_ready | input | 1 | Bus completes the current access |
| mem_addr | output | PTR_W-2 | Shared-memory word address |
| mem_rd_en | output | 1 | Shared-memory read; data returns next cycle |
| mem_rdata | input | DATA_W | Shared-memory read data |
| mem_wr_en | output | 1 | Shared-memory write |
| mem_wdata | output | DATA_W | Shared-memory write data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a rejected command |
| sack_irq | output | 1 | One-cycle acknowledge interrupt |

## Verification
A wrong beat counter shows at the ports within one burst. Either the number of bus handshakes before done differs from desc_len, or done never arrives and desc_ready stays low. A wrong address register shows on lb_addr or mem_addr at the very next access, as a skipped, repeated or moved location. That in turn shows up as wrong contents in the bus device or in shared memory once the command completes. A wrong latch of command flags shows in the completion cycle itself, as a missing, extra or misplaced sack_irq or done_err.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

    localparam logic [4:0] OPC_BUS_WRITE = 5'h0C;
    localparam logic [4:0] OPC_BUS_READ  = 5'h0D;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_WRITE,
        KIND_READ
    } xfer_kind_e;

    typedef enum logic [1:0] {
        DISP_RUN,
        DISP_EMPTY,
        DISP_REJECT
    } dispatch_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_BUS,
        ST_STORE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       irq_en;
        logic       err;
    } cmd_ctl_t;

    function automatic xfer_kind_e classify_op(input logic [4:0] op);
        if (op == OPC_BUS_WRITE) return KIND_WRITE;
        if (op == OPC_BUS_READ)  return KIND_READ;
        return KIND_NONE;
    endfunction

    function automatic logic word_aligned(input logic [1:0] low_bits);
        return low_bits == 2'b00;
    endfunction

endpackage

// File: rtl/ebus_desc_decode.sv
module ebus_desc_decode
    import ebus_seq_pkg::*;
(
    input  logic [4:0] opcode,
    input  logic       len_zero,
    input  logic [1:0] ptr_low,
    output xfer_kind_e kind,
    output dispatch_e  disp
);

    always_comb begin
        kind = classify_op(opcode);
        if (kind == KIND_NONE) begin
            disp = DISP_EMPTY;
        end else if (!word_aligned(ptr_low)) begin
            disp = DISP_REJECT;
        end else if (len_zero) begin
            disp = DISP_EMPTY;
        end else begin
            disp = DISP_RUN;
        end
    end

endmodule

// File: rtl/ebus_addr_gen.sv
module ebus_addr_gen #(
    parameter int BUS_AW = 16,
    parameter int MEM_AW = 14,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [BUS_AW-1:0] base,
    input  logic [MEM_AW-1:0] ptr_word,
    input  logic [LEN_W-1:0]  len,
    input  logic              hold,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              last_beat
);

    logic [BUS_AW-1:0] bus_q;
    logic [MEM_AW-1:0] mem_q;
    logic [LEN_W-1:0]  left_q;
    logic              hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q  <= '0;
            mem_q  <= '0;
            left_q <= '0;
            hold_q <= 1'b0;
        end else if (load) begin
            bus_q  <= base;
            mem_q  <= ptr_word;
            left_q <= len;
            hold_q <= hold;
        end else if (step) begin
            if (!hold_q) begin
                bus_q <= bus_q + 1'b1;
            end
            mem_q  <= mem_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign bus_addr  = bus_q;
    assign mem_addr  = mem_q;
    assign last_beat = (left_q == LEN_W'(1));

    p_inc_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !hold_q) |=> bus_addr == BUS_AW'($past(bus_addr) + 1'b1));

    p_hold_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (step && hold_q) |=> $stable(bus_addr));

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> mem_addr == MEM_AW'($past(mem_addr) + 1'b1));

    p_addr_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> ($stable(bus_addr) && $stable(mem_addr)));

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        step |-> left_q != '0);

endmodule

// File: rtl/ebus_seq_fsm.sv
module ebus_seq_fsm
    import ebus_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  xfer_kind_e        kind_in,
    input  dispatch_e         disp_in,
    input  logic              irq_en_in,
    input  logic [BE_W-1:0]   be_in,
    output logic              load,
    output logic              step,
    input  logic              last_beat,
    output logic              lb_req,
    output logic              lb_we,
    output logic [BE_W-1:0]   lb_be,
    output logic [DATA_W-1:0] lb_wdata,
    input  logic [DATA_W-1:0] lb_rdata,
    input  logic              lb_ready,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done,
    output logic              done_err,
    output logic              sack_irq
);

    seq_state_e        state;
    cmd_ctl_t          ctl;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctl    <= '0;
            be_q   <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (desc_valid) begin
                        ctl.kind   <= kind_in;
                        ctl.irq_en <= irq_en_in;
                        ctl.err    <= (disp_in == DISP_REJECT);
                        be_q       <= be_in;
                        if (disp_in != DISP_RUN) begin
                            state <= ST_DONE;
                        end else if (kind_in == KIND_WRITE) begin
                            state <= ST_FETCH;
                        end else begin
                            state <= ST_BUS;
                        end
                    end
                end
                ST_FETCH: state <= ST_LATCH;
                ST_LATCH: begin
                    data_q <= mem_rdata;
                    state  <= ST_BUS;
                end
                ST_BUS: begin
                    if (lb_ready) begin
                        if (ctl.kind == KIND_READ) begin
                            data_q <= lb_rdata;
                            state  <= ST_STORE;
                        end else begin
                            state <= last_beat ? ST_DONE : ST_FETCH;
                        end
                    end
                end
                ST_STORE: state <= last_beat ? ST_DONE : ST_BUS;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        desc_ready = (state == ST_IDLE);
        load       = desc_ready && desc_valid;
        mem_rd_en  = (state == ST_FETCH);
        mem_wr_en  = (state == ST_STORE);
        mem_wdata  = data_q;
        lb_req     = (state == ST_BUS);
        lb_we      = lb_req && (ctl.kind == KIND_WRITE);
        lb_be      = lb_req ? be_q : '0;
        lb_wdata   = data_q;
        step       = (lb_req && lb_ready && ctl.kind == KIND_WRITE)
                   || (state == ST_STORE);
        done       = (state == ST_DONE);
        done_err   = done && ctl.err;
        sack_irq   = done && ctl.irq_en && !ctl.err;
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (lb_req && !lb_ready) |=> lb_req);

    p_one_cmd_r12: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready) |=> !desc_ready);

    p_ready_after_done_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> desc_ready);

    p_irq_in_done_r11: assert property (@(posedge clk) disable iff (rst)
        sack_irq |-> (done && !done_err));

    p_irq_single_r11: assert property (@(posedge clk) disable iff (rst)
        sack_irq |=> !sack_irq);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done_err |-> $past(desc_ready));

    p_port_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lb_req, mem_rd_en, mem_wr_en, done}));

endmodule

// File: rtl/ebus_xfer_seq.sv
module ebus_xfer_seq
    import ebus_seq_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int PTR_W  = 16,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 32,
    parameter int MEM_AW = PTR_W - 2,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [4:0]        desc_opcode,
    input  logic              desc_irq_en,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [BE_W-1:0]   desc_be,
    input  logic              desc_hold,
    input  logic [PTR_W-1:0]  desc_mem_ptr,
    input  logic [BUS_AW-1:0] desc_bus_base,
    output logic              lb_req,
    output logic              lb_we,
    output logic [BUS_AW-1:0] lb_addr,
    output logic [BE_W-1:0]   lb_be,
    output logic [DATA_W-1:0] lb_wdata,
    input  logic [DATA_W-1:0] lb_rdata,
    input  logic              lb_ready,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done,
    output logic              done_err,
    output logic              sack_irq
);

    xfer_kind_e dec_kind;
    dispatch_e  dec_disp;
    logic       seq_load;
    logic       seq_step;
    logic       seq_last;

    ebus_desc_decode u_decode (
        .opcode   (desc_opcode),
        .len_zero (desc_len == '0),
        .ptr_low  (desc_mem_ptr[1:0]),
        .kind     (dec_kind),
        .disp     (dec_disp)
    );

    ebus_addr_gen #(
        .BUS_AW (BUS_AW),
        .MEM_AW (MEM_AW),
        .LEN_W  (LEN_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (seq_load),
        .step      (seq_step),
        .base      (desc_bus_base),
        .ptr_word  (desc_mem_ptr[PTR_W-1:2]),
        .len       (desc_len),
        .hold      (desc_hold),
        .bus_addr  (lb_addr),
        .mem_addr  (mem_addr),
        .last_beat (seq_last)
    );

    ebus_seq_fsm #(
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .kind_in    (dec_kind),
        .disp_in    (dec_disp),
        .irq_en_in  (desc_irq_en),
        .be_in      (desc_be),
        .load       (seq_load),
        .step       (seq_step),
        .last_beat  (seq_last),
        .lb_req     (lb_req),
        .lb_we      (lb_we),
        .lb_be      (lb_be),
        .lb_wdata   (lb_wdata),
        .lb_rdata   (lb_rdata),
        .lb_ready   (lb_ready),
        .mem_rd_en  (mem_rd_en),
        .mem_rdata  (mem_rdata),
        .mem_wr_en  (mem_wr_en),
        .mem_wdata  (mem_wdata),
        .done       (done),
        .done_err   (done_err),
        .sack_irq   (sack_irq)
    );

    p_done_no_bus_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !lb_req);

endmodule

// File: tb/ebus_xfer_seq_bench.sv
module ebus_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [4:0]  desc_opcode = '0;
    logic        desc_irq_en = 1'b0;
    logic [7:0]  desc_len = '0;
    logic [3:0]  desc_be = '0;
    logic        desc_hold = 1'b0;
    logic [15:0] desc_mem_ptr = '0;
    logic [15:0] desc_bus_base = '0;
    logic        lb_req, lb_we, lb_ready;
    logic [15:0] lb_addr;
    logic [3:0]  lb_be;
    logic [31:0] lb_wdata, lb_rdata;
    logic [13:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_rdata, mem_wdata;
    logic        done, done_err, sack_irq;

    always #2 clk = ~clk;

    ebus_xfer_seq u_ebus_xfer_seq (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_opcode(desc_opcode), .desc_irq_en(desc_irq_en), .desc_len(desc_len),
        .desc_be(desc_be), .desc_hold(desc_hold), .desc_mem_ptr(desc_mem_ptr),
        .desc_bus_base(desc_bus_base), .lb_req(lb_req), .lb_we(lb_we),
        .lb_addr(lb_addr), .lb_be(lb_be), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .lb_ready(lb_ready), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .done(done), .done_err(done_err), .sack_irq(sack_irq)
    );

    // shared memory model, one-cycle read latency
    logic [31:0] smem [0:255];
    logic [31:0] rd_q = '0;
    logic [13:0] mrd_log [0:1023];
    logic [13:0] mwr_log [0:1023];
    int          mrd_cnt = 0;
    int          mwr_cnt = 0;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (mem_rd_en) begin
            rd_q <= smem[mem_addr[7:0]];
            mrd_log[mrd_cnt] <= mem_addr;
            mrd_cnt <= mrd_cnt + 1;
        end
        if (mem_wr_en) begin
            smem[mem_addr[7:0]] <= mem_wdata;
            mwr_log[mwr_cnt] <= mem_addr;
            mwr_cnt <= mwr_cnt + 1;
        end
    end

    // local bus device model
    logic [31:0] dev [0:255];
    logic        stall_en = 1'b0;
    logic        fifo_mode = 1'b0;
    logic [3:0]  tick = '0;
    int          pops = 0;
    logic [15:0] acc_addr [0:1023];
    logic [3:0]  acc_be [0:1023];
    int          acc_cnt = 0;
    int          irq_cnt = 0;
    assign lb_ready = !stall_en || tick[0];
    assign lb_rdata = fifo_mode ? (32'hF1F0_0000 + 32'(pops)) : dev[lb_addr[7:0]];
    always @(posedge clk) begin
        tick <= tick + 1'b1;
        if (sack_irq) irq_cnt <= irq_cnt + 1;
        if (lb_req && lb_ready) begin
            acc_addr[acc_cnt] <= lb_addr;
            acc_be[acc_cnt]   <= lb_be;
            acc_cnt <= acc_cnt + 1;
            if (lb_we) begin
                for (int b = 0; b < 4; b++) begin
                    if (lb_be[b]) dev[lb_addr[7:0]][8*b +: 8] <= lb_wdata[8*b +: 8];
                end
            end else if (fifo_mode) begin
                pops <= pops + 1;
            end
        end
    end

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // snapshots taken at command start
    int s_acc, s_mrd, s_mwr, s_irq;
    bit got_done, got_err, got_irq, busy_bad, ready_after;

    task automatic run_cmd(input logic [4:0] op, input logic irq, input logic [7:0] len,
                           input logic [3:0] be, input logic hold,
                           input logic [15:0] ptr, input logic [15:0] base);
        @(negedge clk);
        s_acc = acc_cnt; s_mrd = mrd_cnt; s_mwr = mwr_cnt; s_irq = irq_cnt;
        got_done = 0; got_err = 0; got_irq = 0; busy_bad = 0; ready_after = 0;
        desc_opcode = op; desc_irq_en = irq; desc_len = len; desc_be = be;
        desc_hold = hold; desc_mem_ptr = ptr; desc_bus_base = base;
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            if (done) begin
                got_done = 1; got_err = done_err; got_irq = sack_irq;
                break;
            end
            if (desc_ready) busy_bad = 1;
            @(negedge clk);
        end
        @(negedge clk);
        ready_after = desc_ready;
        chk(got_done, "R12 command completes", 32'(got_done), 32'd1);
        chk(!busy_bad && ready_after, "R12 ready low while busy, high after done",
            {30'd0, busy_bad, ready_after}, 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(desc_ready && !lb_req && !mem_rd_en && !mem_wr_en && !done && !done_err && !sack_irq,
            "R1 reset outputs",
            {25'd0, desc_ready, lb_req, mem_rd_en, mem_wr_en, done, done_err, sack_irq},
            32'h40);
    endtask

    task automatic t_write_inc();
        bit ok_data = 1, ok_addr = 1, ok_mem = 1, ok_be = 1;
        for (int i = 0; i < 5; i++) smem[16 + i] = 32'hA000_0000 + 32'(i * 17);
        run_cmd(5'h0C, 1'b1, 8'd5, 4'hF, 1'b0, 16'd64, 16'h0020);
        chk(acc_cnt - s_acc == 5, "R2 write beat count", 32'(acc_cnt - s_acc), 32'd5);
        for (int i = 0; i < 5; i++) begin
            if (dev[8'h20 + 8'(i)] != 32'hA000_0000 + 32'(i * 17)) ok_data = 0;
            if (acc_addr[s_acc + i] != 16'h0020 + 16'(i)) ok_addr = 0;
            if (mrd_log[s_mrd + i] != 14'd16 + 14'(i)) ok_mem = 0;
            if (acc_be[s_acc + i] != 4'hF) ok_be = 0;
        end
        chk(ok_data, "R2 write data on bus", dev[8'h24], 32'hA000_0044);
        chk(ok_addr, "R4 incrementing bus addresses", 32'(acc_addr[s_acc + 4]), 32'h24);
        chk(ok_mem && mrd_cnt - s_mrd == 5, "R7 memory read addresses",
            32'(mrd_cnt - s_mrd), 32'd5);
        chk(ok_be, "R6 full byte enables", 32'(acc_be[s_acc]), 32'hF);
        chk(got_irq && irq_cnt - s_irq == 1, "R11 irq once when enabled",
            32'(irq_cnt - s_irq), 32'd1);
    endtask

    task automatic t_read_inc_stall();
        bit ok_data = 1, ok_addr = 1, ok_mem = 1;
        for (int i = 0; i < 4; i++) dev[8'h40 + 8'(i)] = 32'h5EED_0000 + 32'(i);
        stall_en = 1'b1;
        run_cmd(5'h0D, 1'b0, 8'd4, 4'hF, 1'b0, 16'h0100, 16'h0040);
        stall_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (smem[64 + i] != 32'h5EED_0000 + 32'(i)) ok_data = 0;
            if (acc_addr[s_acc + i] != 16'h0040 + 16'(i)) ok_addr = 0;
            if (mwr_log[s_mwr + i] != 14'd64 + 14'(i)) ok_mem = 0;
        end
        chk(ok_data, "R3 read data into memory", smem[67], 32'h5EED_0003);
        chk(ok_addr && acc_cnt - s_acc == 4, "R4 read addresses with stalls",
            32'(acc_cnt - s_acc), 32'd4);
        chk(ok_mem, "R7 memory write addresses", 32'(mwr_log[s_mwr + 3]), 32'd67);
        chk(!got_irq && irq_cnt == s_irq, "R11 no irq when disabled",
            32'(irq_cnt - s_irq), 32'd0);
    endtask

    task automatic t_write_hold();
        logic [31:0] expv = 32'hAAAA_AAAA;
        bit ok_addr = 1, ok_be = 1;
        dev[8'h30] = 32'hAAAA_AAAA;
        for (int i = 0; i < 3; i++) begin
            smem[32 + i] = 32'h1122_3300 + 32'(i);
            expv = (expv & 32'hFF00_FF00) | ((32'h1122_3300 + 32'(i)) & 32'h00FF_00FF);
        end
        run_cmd(5'h0C, 1'b0, 8'd3, 4'b0101, 1'b1, 16'h0080, 16'h0030);
        for (int i = 0; i < 3; i++) begin
            if (acc_addr[s_acc + i] != 16'h0030) ok_addr = 0;
            if (acc_be[s_acc + i] != 4'b0101) ok_be = 0;
        end
        chk(ok_addr && acc_cnt - s_acc == 3, "R5 hold address on write",
            32'(acc_addr[s_acc + 2]), 32'h30);
        chk(ok_be, "R6 partial byte enables", 32'(acc_be[s_acc]), 32'h5);
        chk(dev[8'h30] == expv, "R6 byte lanes merged", dev[8'h30], expv);
        chk(mrd_log[s_mrd + 2] == 14'd34, "R7 pointer advances in hold mode",
            32'(mrd_log[s_mrd + 2]), 32'd34);
    endtask

    task automatic t_read_hold_fifo();
        int p0;
        bit ok_data = 1, ok_addr = 1;
        p0 = pops;
        fifo_mode = 1'b1;
        run_cmd(5'h0D, 1'b1, 8'd4, 4'hF, 1'b1, 16'h0140, 16'h0077);
        fifo_mode = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (smem[80 + i] != 32'hF1F0_0000 + 32'(p0 + i)) ok_data = 0;
            if (acc_addr[s_acc + i] != 16'h0077) ok_addr = 0;
        end
        chk(ok_addr && acc_cnt - s_acc == 4, "R5 hold address on read",
            32'(acc_addr[s_acc + 3]), 32'h77);
        chk(ok_data, "R3 fifo words stored in order", smem[83], 32'hF1F0_0000 + 32'(p0 + 3));
        chk(got_irq, "R11 irq on read completion", 32'(got_irq), 32'd1);
    endtask

    task automatic t_len_zero();
        run_cmd(5'h0C, 1'b1, 8'd0, 4'hF, 1'b0, 16'h0010, 16'h0000);
        chk(acc_cnt == s_acc && mrd_cnt == s_mrd && mwr_cnt == s_mwr,
            "R8 zero length makes no access", 32'(acc_cnt - s_acc), 32'd0);
        chk(got_irq && !got_err, "R8 zero length irq", {30'd0, got_irq, got_err}, 32'd2);
    endtask

    task automatic t_misaligned();
        run_cmd(5'h0D, 1'b1, 8'd3, 4'hF, 1'b0, 16'h0042, 16'h0010);
        chk(acc_cnt == s_acc && mrd_cnt == s_mrd && mwr_cnt == s_mwr,
            "R9 misaligned makes no access", 32'(acc_cnt - s_acc), 32'd0);
        chk(got_err && !got_irq && irq_cnt == s_irq, "R9 error flagged without irq",
            {30'd0, got_err, got_irq}, 32'd2);
        run_cmd(5'h0C, 1'b0, 8'd0, 4'hF, 1'b0, 16'h0003, 16'h0010);
        chk(got_err, "R9 misaligned wins over zero length", 32'(got_err), 32'd1);
    endtask

    task automatic t_bad_opcode();
        run_cmd(5'h1F, 1'b1, 8'd6, 4'hF, 1'b0, 16'h0041, 16'h0010);
        chk(acc_cnt == s_acc && mrd_cnt == s_mrd && mwr_cnt == s_mwr,
            "R10 unknown opcode makes no access", 32'(acc_cnt - s_acc), 32'd0);
        chk(got_irq && !got_err, "R10 unknown opcode irq", {30'd0, got_irq, got_err}, 32'd2);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i] = 32'hDEAD_0000 + 32'(i);
            dev[i]  = 32'hBEEF_0000 + 32'(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_inc();
        t_read_inc_stall();
        t_write_hold();
        t_read_hold_fifo();
        t_len_zero();
        t_misaligned();
        t_bad_opcode();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule